// File: doc/BRIEF.md
# Serial EEPROM Slave Model (16 x 16 bit)

This block models a small serial EEPROM that holds sixteen 16-bit words. A host reaches it over a three-wire serial link: a select line, a serial clock and a data input, plus a serial data output that has its own drive enable. All four serial pins are sampled in the system clock domain. A rising serial-clock edge counts as a bit when the system clock sees the serial clock high after it was low the cycle before.

A command opens with a start bit. Two opcode bits and an address field follow. Commands that carry data then take sixteen data bits. The block can read one word, program one word, erase one word, erase or program every word, and set or clear a write-enable latch that guards all programming. Programming and erasing are self-timed. The length of each kind of cycle is a parameter counted in system clocks, and a cycle keeps running after the select line falls. A host that raises select again during a cycle sees busy or ready on the data output.

Top module: `mw_eeprom`

## Requirements
- R1: While select is high and no command has started, rising serial-clock edges with data-in low change nothing. The first 1 sampled is taken as the start bit.
- R2: After the start bit the block shifts in the opcode (two bits) and then the address field (two selector bits, then A3..A0), MSB first. Opcode 10 reads, 01 programs one word, 11 erases one word.
- R3: With opcode 00 the selector bits choose the command: 11 sets the write-enable latch, 00 clears it, 10 erases every word and 01 programs every word. A3..A0 are ignored.
- R4: A single-word program and a program-all each take 16 data bits, MSB first, so the command ends on serial edge 25. Every other command ends on edge 9.
- R5: On a read, data out is driven from edge 9 and first shows a 0. Each later edge moves it to the next bit, D15 down to D0.
- R6: One system clock after select is sampled low, the serial logic is back in its idle state and data out is not driven. A command that was cut short has no effect.
- R7: Reset clears the write-enable latch and sets every word to 0. While the latch is clear, the four programming commands change no word and start no busy period.
- R8: A single-word erase and an erase-all write 16'hFFFF. A program-all writes its data word to every address.
- R9: A programming cycle starts one clock after the last command bit. It lasts T_WORD_CYC clocks for a single-word program, T_ERASE_CYC for a single-word erase and T_BULK_CYC for an erase-all or program-all. The word or words are written when it ends. It continues with select low, and start bits are ignored while it runs.
- R10: If select rises while a cycle is running, data out is driven from the next clock, low while busy and high once ready, until select falls. If select stays high from the command through the cycle, data out stays undriven.
- R11: Serial edges that follow a completed command are ignored until select falls. After a read's D0, data out holds D0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all serial pins are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out (read data or ready/busy) |
| sdo_oe | output | 1 | Drive enable for sdo; low means high impedance |

## Verification
A serial edge takes effect at the first system clock that sees the serial clock high. Read bits and the end of the command therefore show on the pins one clock after that edge. The bench moves the serial clock and data on falling system-clock edges and samples at the falling edge after the rise. Status appears one clock after select is raised again. Busy starts one clock after the last command bit and lasts exactly its parameter. Because the reselect adds a few clocks, each timed check samples ten clocks before the expected end of busy and again about ten after it. Those samples must read busy and then ready.

// File: rtl/mw_pkg.sv
`timescale 1ns/1ps
// Shared types for the serial EEPROM slave: command codes, front-end
// states and the command decode helpers.
package mw_pkg;

    typedef enum logic [2:0] {
        CMD_READ,
        CMD_WRITE,
        CMD_ERASE,
        CMD_UNLOCK,
        CMD_LOCK,
        CMD_ERASE_ALL,
        CMD_WRITE_ALL
    } cmd_e;

    typedef enum logic [2:0] {
        FE_IDLE,
        FE_HDR,
        FE_DATA,
        FE_READ,
        FE_DONE
    } fe_e;

    // Map opcode and the two selector bits of the address field to a command.
    function automatic cmd_e decode(input logic [1:0] op, input logic [1:0] selb);
        cmd_e c;
        case (op)
            2'b10:   c = CMD_READ;
            2'b01:   c = CMD_WRITE;
            2'b11:   c = CMD_ERASE;
            default: begin
                case (selb)
                    2'b11:   c = CMD_UNLOCK;
                    2'b00:   c = CMD_LOCK;
                    2'b10:   c = CMD_ERASE_ALL;
                    default: c = CMD_WRITE_ALL;
                endcase
            end
        endcase
        return c;
    endfunction

    // Commands that take a trailing data word.
    function automatic logic has_data(input cmd_e c);
        return (c == CMD_WRITE) || (c == CMD_WRITE_ALL);
    endfunction

    // Commands that start a self-timed programming cycle.
    function automatic logic is_prog(input cmd_e c);
        return (c == CMD_WRITE) || (c == CMD_ERASE) ||
               (c == CMD_ERASE_ALL) || (c == CMD_WRITE_ALL);
    endfunction

endpackage

// File: rtl/mw_frontend.sv
`timescale 1ns/1ps
// Serial front end. Detects rising serial-clock edges in the system clock
// domain, waits for a start bit, shifts in header and data, and issues a
// one-cycle command pulse. Also serialises read data.
// Assumes sclk/sel/sdi are already synchronous to clk and that the serial
// clock stays at each level for at least one system clock.
module mw_frontend
    import mw_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              sclk,
    input  logic              sdi,
    input  logic              busy,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              go,
    output cmd_e              cmd,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data,
    output logic              rd_bit,
    output logic              rd_oe
);
    localparam int HB = ADDR_W + 4;
    localparam int CW = $clog2(DATA_W + HB + 1);

    fe_e               st;
    logic              sk_q;
    logic              rise;
    logic [CW-1:0]     cnt;
    logic [HB-1:0]     hdr_q;
    logic [HB-1:0]     hdr_nx;
    logic [DATA_W:0]   rd_sh;
    cmd_e              dec;

    assign rise    = sclk & ~sk_q;
    assign hdr_nx  = {hdr_q[HB-2:0], sdi};
    assign rd_addr = hdr_nx[ADDR_W-1:0];
    assign dec     = decode(hdr_nx[HB-1:HB-2], hdr_nx[ADDR_W+1:ADDR_W]);
    assign rd_bit  = rd_sh[DATA_W];

    // Remember the previous serial-clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sk_q <= 1'b0;
        else        sk_q <= sclk;
    end

    // Command sequencer: start detection, header/data shifting, read output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= FE_IDLE;
            cnt   <= '0;
            go    <= 1'b0;
            rd_oe <= 1'b0;
            hdr_q <= '0;
            rd_sh <= '0;
            cmd   <= CMD_LOCK;
            addr  <= '0;
            data  <= '0;
        end else if (!sel) begin
            st    <= FE_IDLE;
            cnt   <= '0;
            go    <= 1'b0;
            rd_oe <= 1'b0;
        end else begin
            go <= 1'b0;
            if (rise) begin
                case (st)
                    FE_IDLE: begin
                        if (sdi && !busy) begin
                            st  <= FE_HDR;
                            cnt <= '0;
                        end
                    end
                    FE_HDR: begin
                        hdr_q <= hdr_nx;
                        cnt   <= cnt + CW'(1);
                        if (cnt == CW'(HB - 1)) begin
                            cmd  <= dec;
                            addr <= rd_addr;
                            cnt  <= '0;
                            if (dec == CMD_READ) begin
                                st    <= FE_READ;
                                rd_sh <= {1'b0, rd_data};
                                rd_oe <= 1'b1;
                            end else if (has_data(dec)) begin
                                st <= FE_DATA;
                            end else begin
                                st <= FE_DONE;
                                go <= 1'b1;
                            end
                        end
                    end
                    FE_DATA: begin
                        data <= {data[DATA_W-2:0], sdi};
                        cnt  <= cnt + CW'(1);
                        if (cnt == CW'(DATA_W - 1)) begin
                            st <= FE_DONE;
                            go <= 1'b1;
                        end
                    end
                    FE_READ: begin
                        if (cnt != CW'(DATA_W)) begin
                            rd_sh <= {rd_sh[DATA_W-1:0], 1'b0};
                            cnt   <= cnt + CW'(1);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/mw_prog.sv
`timescale 1ns/1ps
// Programming control: write-enable latch, self-timed cycle counter,
// pending write request and ready/busy status flag.
// Assumes go is a single-cycle pulse that never arrives while busy.
module mw_prog
    import mw_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 16,
    parameter int T_WORD_CYC  = 250000,
    parameter int T_ERASE_CYC = 125000,
    parameter int T_BULK_CYC  = 1875000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              go,
    input  cmd_e              cmd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              busy,
    output logic              wen,
    output logic              wr_en,
    output logic              wr_bulk,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_val,
    output logic              stat
);
    localparam int TM1 = (T_WORD_CYC > T_ERASE_CYC) ? T_WORD_CYC : T_ERASE_CYC;
    localparam int TMX = (TM1 > T_BULK_CYC) ? TM1 : T_BULK_CYC;
    localparam int CW  = $clog2(TMX + 1);

    logic [CW-1:0] tcnt;
    logic          sel_q;

    // Previous select level, used to spot a reselect.
    always_ff @(posedge clk) begin
        sel_q <= sel;
    end

    // Latch, cycle timer and pending write; write pulse when the timer expires.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wen     <= 1'b0;
            busy    <= 1'b0;
            tcnt    <= '0;
            wr_en   <= 1'b0;
            wr_bulk <= 1'b0;
            wr_addr <= '0;
            wr_val  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (go) begin
                case (cmd)
                    CMD_UNLOCK: wen <= 1'b1;
                    CMD_LOCK:   wen <= 1'b0;
                    default: ;
                endcase
                if (is_prog(cmd) && wen) begin
                    busy    <= 1'b1;
                    wr_addr <= addr;
                    wr_bulk <= (cmd == CMD_ERASE_ALL) || (cmd == CMD_WRITE_ALL);
                    wr_val  <= ((cmd == CMD_WRITE) || (cmd == CMD_WRITE_ALL)) ? data : '1;
                    case (cmd)
                        CMD_WRITE: tcnt <= CW'(T_WORD_CYC - 1);
                        CMD_ERASE: tcnt <= CW'(T_ERASE_CYC - 1);
                        default:   tcnt <= CW'(T_BULK_CYC - 1);
                    endcase
                end
            end
            if (busy) begin
                if (tcnt == '0) begin
                    busy  <= 1'b0;
                    wr_en <= 1'b1;
                end else begin
                    tcnt <= tcnt - CW'(1);
                end
            end
        end
    end

    // Status output flag: set on reselect during a cycle, cleared by deselect.
    always_ff @(posedge clk) begin
        if (!rst_n || !sel) stat <= 1'b0;
        else if (!sel_q && busy) stat <= 1'b1;
    end
endmodule

// File: rtl/mw_array.sv
`timescale 1ns/1ps
// Word storage with one combinational read port and one write port that
// updates either a single word or every word at once.
// Assumes wr_en is a single-cycle pulse.
module mw_array #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_bulk,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_val,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    assign rd_data = mem[rd_addr];

    // Clear on reset, then apply single or bulk writes.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) mem[i] <= '0;
            else if (wr_en && (wr_bulk || (wr_addr == ADDR_W'(i)))) mem[i] <= wr_val;
        end
    end
endmodule

// File: rtl/mw_eeprom.sv
`timescale 1ns/1ps
// Top of the serial EEPROM slave: joins the serial front end, the
// programming control and the storage array, and muxes the data output
// between read data and ready/busy status.
// Assumes all serial inputs are synchronous to clk.
module mw_eeprom
    import mw_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 16,
    parameter int T_WORD_CYC  = 250000,
    parameter int T_ERASE_CYC = 125000,
    parameter int T_BULK_CYC  = 1875000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic sclk,
    input  logic sdi,
    output logic sdo,
    output logic sdo_oe
);
    logic              busy, wen, go, wr_en, wr_bulk, stat, rd_bit, rd_oe;
    cmd_e              cmd;
    logic [ADDR_W-1:0] addr, rd_addr, wr_addr;
    logic [DATA_W-1:0] data, rd_data, wr_val;

    mw_frontend #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fe (
        .clk(clk), .rst_n(rst_n), .sel(sel), .sclk(sclk), .sdi(sdi),
        .busy(busy), .rd_data(rd_data), .rd_addr(rd_addr), .go(go),
        .cmd(cmd), .addr(addr), .data(data), .rd_bit(rd_bit), .rd_oe(rd_oe)
    );

    mw_prog #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .T_WORD_CYC(T_WORD_CYC),
        .T_ERASE_CYC(T_ERASE_CYC), .T_BULK_CYC(T_BULK_CYC)
    ) u_prog (
        .clk(clk), .rst_n(rst_n), .sel(sel), .go(go), .cmd(cmd),
        .addr(addr), .data(data), .busy(busy), .wen(wen), .wr_en(wr_en),
        .wr_bulk(wr_bulk), .wr_addr(wr_addr), .wr_val(wr_val), .stat(stat)
    );

    mw_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bulk(wr_bulk),
        .wr_addr(wr_addr), .wr_val(wr_val), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    assign sdo    = stat ? ~busy : rd_bit;
    assign sdo_oe = stat | rd_oe;
endmodule

// File: rtl/mw_eeprom_checker.sv
`timescale 1ns/1ps
// Protocol and timing properties of the serial EEPROM slave, bound to the top.
module mw_eeprom_checker
    import mw_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic sel,
    input logic oe,
    input logic busy,
    input logic go,
    input logic wen,
    input cmd_e cmd,
    input logic wr_en
);
    assert_hiz_after_deselect_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> !oe);

    assert_locked_no_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !wen && is_prog(cmd)) |=> !busy);

    assert_cycle_ends_in_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || wr_en));

    assert_write_only_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !wr_en);

    assert_status_on_reselect_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sel) && busy) |=> oe);
endmodule

bind mw_eeprom mw_eeprom_checker u_chk (
    .clk(clk), .rst_n(rst_n), .sel(sel), .oe(sdo_oe), .busy(busy),
    .go(go), .wen(wen), .cmd(cmd), .wr_en(wr_en)
);

// File: tb/mw_eeprom_bench.sv
`timescale 1ns/1ps
module mw_eeprom_bench;
    localparam int TW = 200;
    localparam int TE = 100;
    localparam int TB = 400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel = 1'b0;
    logic sclk = 1'b0;
    logic sdi = 1'b0;
    logic sdo, sdo_oe;
    int   n_chk = 0;
    int   n_bad = 0;

    always #4 clk = ~clk;

    mw_eeprom #(.T_WORD_CYC(TW), .T_ERASE_CYC(TE), .T_BULK_CYC(TB)) u_mw_eeprom (
        .clk(clk), .rst_n(rst_n), .sel(sel), .sclk(sclk), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // One serial bit: data and clock high on a falling edge, clock low one cycle later.
    task automatic sbit(input logic b);
        sdi  = b;
        sclk = 1'b1;
        @(negedge clk);
        sclk = 1'b0;
        @(negedge clk);
    endtask

    task automatic shift(input logic [31:0] bits, input int n);
        for (int i = n - 1; i >= 0; i--) sbit(bits[i]);
    endtask

    task automatic deselect();
        sel = 1'b0;
        sdi = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run_cmd(input logic [31:0] bits, input int n);
        sel = 1'b1;
        shift(bits, n);
        deselect();
    endtask

    task automatic wait_ready(input string req);
        int k = 0;
        sel = 1'b1;
        @(negedge clk);
        while (!(sdo_oe === 1'b1 && sdo === 1'b1) && k < 3000) begin
            @(negedge clk);
            k++;
        end
        chk({req, " ready reached"}, {31'd0, sdo_oe & sdo}, 32'd1);
        deselect();
    endtask

    task automatic read_word(input logic [3:0] a, output logic [15:0] w);
        sel = 1'b1;
        shift({23'd0, 1'b1, 2'b10, 2'b00, a}, 9);
        chk("R5 dummy zero driven", {30'd0, sdo_oe, sdo}, 32'h2);
        for (int i = 15; i >= 0; i--) begin
            sbit(1'b0);
            w[i] = sdo;
        end
        deselect();
    endtask

    task automatic t_reset();
        logic [15:0] w;
        chk("R6 reset output undriven", {31'd0, sdo_oe}, 32'd0);
        read_word(4'd3, w);
        chk("R7 reset word is zero", {16'd0, w}, 32'd0);
    endtask

    task automatic t_locked();
        logic [15:0] w;
        run_cmd({7'd0, 1'b1, 2'b01, 2'b00, 4'd5, 16'h1234}, 25);
        sel = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R7 locked write starts no busy", {31'd0, sdo_oe}, 32'd0);
        deselect();
        read_word(4'd5, w);
        chk("R7 locked write leaves word", {16'd0, w}, 32'd0);
    endtask

    // Timed program: cmd with select held high, then reselect and watch status.
    task automatic timed(input string req, input logic [31:0] bits, input int n, input int t);
        sel = 1'b1;
        shift(bits, n);
        chk({req, " R10 no status with select held"}, {31'd0, sdo_oe}, 32'd0);
        sel = 1'b0;
        @(negedge clk);
        sel = 1'b1;
        @(negedge clk);
        chk({req, " R10 busy shown on reselect"}, {30'd0, sdo_oe, sdo}, 32'h2);
        repeat (t - 10) @(negedge clk);
        chk({req, " R9 still busy before end"}, {30'd0, sdo_oe, sdo}, 32'h2);
        repeat (20) @(negedge clk);
        chk({req, " R9 ready after end"}, {30'd0, sdo_oe, sdo}, 32'h3);
        deselect();
    endtask

    task automatic t_write_timed();
        logic [15:0] w;
        run_cmd({23'd0, 1'b1, 2'b00, 2'b11, 4'd0}, 9);
        timed("R4 write", {4'd0, 3'b000, 1'b1, 2'b01, 2'b00, 4'd5, 16'hA5C3}, 28, TW);
        read_word(4'd5, w);
        chk("R1 R2 R4 written word after leading zeros", {16'd0, w}, 32'h0000A5C3);
    endtask

    task automatic t_read_detail();
        logic [15:0] w;
        sel = 1'b1;
        shift({23'd0, 1'b1, 2'b10, 2'b00, 4'd5}, 9);
        chk("R5 first driven bit is zero", {30'd0, sdo_oe, sdo}, 32'h2);
        for (int i = 15; i >= 0; i--) begin
            sbit(1'b1);
            w[i] = sdo;
        end
        chk("R5 bits D15..D0 in order", {16'd0, w}, 32'h0000A5C3);
        sbit(1'b0);
        sbit(1'b0);
        chk("R11 extra edges hold D0", {30'd0, sdo_oe, sdo}, 32'h3);
        sel = 1'b0;
        @(negedge clk);
        chk("R6 deselect releases output", {31'd0, sdo_oe}, 32'd0);
        @(negedge clk);
    endtask

    task automatic t_erase_timed();
        logic [15:0] w;
        timed("R8 erase", {23'd0, 1'b1, 2'b11, 2'b00, 4'd5}, 9, TE);
        read_word(4'd5, w);
        chk("R8 erased word all ones", {16'd0, w}, 32'h0000FFFF);
    endtask

    task automatic t_abandon();
        logic [15:0] w;
        sel = 1'b1;
        shift({20'd0, 1'b1, 2'b01, 2'b00, 4'd5, 3'b000}, 12);
        deselect();
        read_word(4'd5, w);
        chk("R6 cut-short write has no effect", {16'd0, w}, 32'h0000FFFF);
    endtask

    task automatic t_busy_ignores();
        logic [15:0] w;
        run_cmd({7'd0, 1'b1, 2'b01, 2'b00, 4'd6, 16'h6060}, 25);
        run_cmd({23'd0, 1'b1, 2'b00, 2'b00, 4'd0}, 9);
        wait_ready("R9 word cycle");
        run_cmd({7'd0, 1'b1, 2'b01, 2'b00, 4'd7, 16'h7777}, 25);
        wait_ready("R9 second write");
        read_word(4'd6, w);
        chk("R9 write completed with select low", {16'd0, w}, 32'h00006060);
        read_word(4'd7, w);
        chk("R9 lock sent while busy was ignored", {16'd0, w}, 32'h00007777);
    endtask

    task automatic t_extra_edges();
        logic [15:0] w;
        run_cmd({23'd0, 1'b1, 2'b00, 2'b00, 4'd0}, 9);
        sel = 1'b1;
        shift({23'd0, 1'b1, 2'b00, 2'b11, 4'd0}, 9);
        shift({23'd0, 1'b1, 2'b00, 2'b00, 4'd0}, 9);
        deselect();
        run_cmd({7'd0, 1'b1, 2'b01, 2'b00, 4'd8, 16'h0808}, 25);
        wait_ready("R11 write after unlock");
        read_word(4'd8, w);
        chk("R11 trailing lock bits ignored", {16'd0, w}, 32'h00000808);
    endtask

    task automatic t_bulk();
        logic [15:0] w;
        int bad = 0;
        timed("R3 write-all", {7'd0, 1'b1, 2'b00, 2'b01, 4'd9, 16'h5A5A}, 25, TB);
        for (int a = 0; a < 16; a++) begin
            read_word(4'(a), w);
            if (w !== 16'h5A5A) bad++;
        end
        chk("R8 write-all fills every word", bad, 32'd0);
        run_cmd({23'd0, 1'b1, 2'b00, 2'b10, 4'd3}, 9);
        wait_ready("R3 erase-all");
        bad = 0;
        for (int a = 0; a < 16; a++) begin
            read_word(4'(a), w);
            if (w !== 16'hFFFF) bad++;
        end
        chk("R8 erase-all sets every word", bad, 32'd0);
    endtask

    task automatic t_locked_bulk();
        logic [15:0] w;
        run_cmd({23'd0, 1'b1, 2'b00, 2'b00, 4'd15}, 9);
        run_cmd({7'd0, 1'b1, 2'b00, 2'b01, 4'd0, 16'h1111}, 25);
        sel = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R7 locked write-all starts no busy", {31'd0, sdo_oe}, 32'd0);
        deselect();
        read_word(4'd0, w);
        chk("R3 R7 lock blocks write-all", {16'd0, w}, 32'h0000FFFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_locked();
        t_write_timed();
        t_read_detail();
        t_erase_timed();
        t_abandon();
        t_busy_ignores();
        t_extra_edges();
        t_bulk();
        t_locked_bulk();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule